// File: doc/BRIEF.md
# Oversampling Asynchronous Character Receiver

This block recovers asynchronous serial characters from a single receive line and hands each one to a downstream FIFO write port. It can run in two ways. In the first, it oversamples the line on a strobe that fires sixteen times per bit. In the second, it takes one sample per bit on the rising edge of an external sample clock. The line and the external clock both pass through a synchroniser before use. A state machine walks through the states HUNT, START, DATA, PARITY, STOP1 and STOP2. It assembles 5 to 9 data bits, least significant bit first. It then checks an optional parity bit and one or two stop bits, and emits a word with parity-error, framing-error and break flags on a one-cycle strobe.

These are the transitions. HUNT→START happens on a low sample in oversampled mode; that sample is sample 0. HUNT→DATA happens on a low sample at an external clock edge in 1x mode. START→HUNT is a false start: the line is high at sample 8. START→DATA happens at the end of the start bit. DATA→PARITY or DATA→STOP1 happens after the last data bit, depending on whether parity is on. PARITY→STOP1 happens after the parity bit. STOP1→HUNT happens at the centre of the stop bit when one stop bit is set. STOP1→STOP2 happens at the end of the first stop bit when two are set. STOP2→HUNT happens at the centre of the second stop bit.

The receiver goes back to HUNT at the centre of the final stop bit and does not wait for the end of that bit. A transmitter whose stop bit is shortened, and which sends the next start bit at once, is therefore still received correctly. The baud strobe generator, the FIFO and any register access sit outside this block.

Top module: `async_rx_engine`

## Requirements
- R1: After reset `out_valid` is low, and no word is produced while the line stays high.
- R2: In oversampled mode, a low sample in HUNT starts a character as sample 0. If the synchronised line is high at sample 8, the character is dropped with no output.
- R3: In oversampled mode each data, parity and stop bit takes the majority of samples 7, 8 and 9 of that bit. Bit edges displaced by up to 3 samples, and a single-sample glitch at the bit centre, do not change the result.
- R4: `cfg_len` selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. `out_data[k]` holds the k-th received data bit, and bits at or above the length are zero.
- R5: With `par_en`=1 one parity bit follows the data. `par_odd`=0 expects an even count of ones over data plus parity, and `par_odd`=1 expects an odd count. `out_perr` is 1 on a mismatch and always 0 with `par_en`=0.
- R6: `two_stop` selects one or two stop bits. `out_ferr` is 1 when any sampled stop bit is low.
- R7: `out_brk` is 1 when the data, parity and stop samples are all low. `out_ferr` is then also 1.
- R8: The receiver returns to HUNT at the centre of the final stop bit. A stop bit held for only 10 samples, followed at once by the next start bit, yields both characters with `out_ferr`=0.
- R9: Each character produces `out_valid` for exactly one clock cycle, and the word fields are valid in that cycle.
- R10: With `mode_1x`=1 each rising edge of `ext_clk` takes one sample of the line. The first low sample is the start bit, and each later edge takes the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_1x | input | 1 | 1 selects one sample per `ext_clk` rising edge; 0 selects 16x oversampling |
| os_tick | input | 1 | Oversampling strobe, sixteen per bit time |
| ext_clk | input | 1 | External 1x sample clock, synchronised inside |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len | input | 4 | Number of data bits, 5 to 9 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits |
| out_valid | output | 1 | One-cycle strobe for a received word |
| out_data | output | 9 | Data bits; bit 8 is the ninth bit |
| out_perr | output | 1 | Parity error |
| out_ferr | output | 1 | Framing error |
| out_brk | output | 1 | Break detected |

## Verification
The bench builds the block with its defaults: sixteen samples per bit, two synchroniser stages and a nine-bit data path. The strobe fires every fourth clock, so a bit lasts 64 clocks. At sixteen samples per bit, the sample-8 start check, the 7-8-9 majority and the 10-sample short stop all fall on exact sample positions the bench can place, including edges moved by three samples and a glitch on sample 8. The full 9-bit path brings the ninth bit and every length from 5 to 9 within reach of the random frames, in both the oversampled and 1x modes.

// File: rtl/rx_eng_pkg.sv
package rx_eng_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic ext_clk,
    output logic rxd_s,
    output logic ext_rise
);
    logic [STAGES-1:0] rx_q;
    logic [STAGES-1:0] ck_q;
    logic              ck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '1;
            ck_q <= '0;
            ck_d <= 1'b0;
        end else begin
            rx_q <= {rx_q[STAGES-2:0], rxd};
            ck_q <= {ck_q[STAGES-2:0], ext_clk};
            ck_d <= ck_q[STAGES-1];
        end
    end

    assign rxd_s    = rx_q[STAGES-1];
    assign ext_rise = ck_q[STAGES-1] & ~ck_d;
endmodule

// File: rtl/rx_os_sampler.sv
module rx_os_sampler #(
    parameter int OS_RATE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic rxd_s,
    output logic centre_hit,
    output logic vote_hit,
    output logic end_hit,
    output logic vote
);
    import rx_eng_pkg::*;

    localparam int CW     = $clog2(OS_RATE);
    localparam int CENTRE = OS_RATE / 2;

    logic [CW-1:0] cnt;
    logic [1:0]    hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            hist <= 2'b11;
        end else begin
            if (restart)
                cnt <= CW'(1);
            else if (tick)
                cnt <= (cnt == CW'(OS_RATE - 1)) ? '0 : cnt + 1'b1;
            if (tick)
                hist <= {hist[0], rxd_s};
        end
    end

    assign centre_hit = tick && (cnt == CW'(CENTRE));
    assign vote_hit   = tick && (cnt == CW'(CENTRE + 1));
    assign end_hit    = tick && (cnt == CW'(OS_RATE - 1));
    assign vote       = maj3(hist[1], hist[0], rxd_s);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && cnt != CW'(OS_RATE - 1)) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm #(
    parameter int MAX_DATA = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_1x,
    input  logic                os_tick,
    input  logic                rxd_s,
    input  logic                ext_rise,
    input  logic                centre_hit,
    input  logic                vote_hit,
    input  logic                end_hit,
    input  logic                vote,
    input  logic [3:0]          cfg_len,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    output logic                restart,
    output logic                out_valid,
    output logic [MAX_DATA-1:0] out_data,
    output logic                out_perr,
    output logic                out_ferr,
    output logic                out_brk
);
    import rx_eng_pkg::*;

    rx_state_e          state, state_nx;
    logic [MAX_DATA-1:0] shreg;
    logic [3:0]          idx;
    logic [3:0]          eff_len;
    logic                par_bit, low_all, stop_bad;
    logic                cap, cap_val, adv, last_bit, final_cap;

    assign eff_len  = (cfg_len < 4'd5) ? 4'd5 :
                      (cfg_len > 4'(MAX_DATA)) ? 4'(MAX_DATA) : cfg_len;
    assign cap      = mode_1x ? ext_rise : vote_hit;
    assign cap_val  = mode_1x ? rxd_s : vote;
    assign adv      = mode_1x ? ext_rise : end_hit;
    assign last_bit = (idx == eff_len - 4'd1);
    assign restart  = !mode_1x && (state == ST_HUNT) && os_tick && !rxd_s;
    assign final_cap = cap && (((state == ST_STOP1) && !two_stop) || (state == ST_STOP2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: begin
                if (mode_1x && ext_rise && !rxd_s) state_nx = ST_DATA;
                else if (restart)                  state_nx = ST_START;
            end
            ST_START: begin
                if (centre_hit && rxd_s) state_nx = ST_HUNT;
                else if (end_hit)        state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (adv && last_bit) state_nx = par_en ? ST_PARITY : ST_STOP1;
            end
            ST_PARITY: begin
                if (adv) state_nx = ST_STOP1;
            end
            ST_STOP1: begin
                if (cap && !two_stop)     state_nx = ST_HUNT;
                else if (adv && two_stop) state_nx = ST_STOP2;
            end
            ST_STOP2: begin
                if (cap) state_nx = ST_HUNT;
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            idx       <= '0;
            par_bit   <= 1'b0;
            low_all   <= 1'b1;
            stop_bad  <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_perr  <= 1'b0;
            out_ferr  <= 1'b0;
            out_brk   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (state == ST_HUNT && state_nx != ST_HUNT) begin
                shreg    <= '0;
                idx      <= '0;
                par_bit  <= 1'b0;
                low_all  <= 1'b1;
                stop_bad <= 1'b0;
            end
            if (state == ST_DATA) begin
                if (cap) begin
                    shreg[idx] <= cap_val;
                    low_all    <= low_all & ~cap_val;
                end
                if (adv) idx <= idx + 4'd1;
            end
            if (state == ST_PARITY && cap) begin
                par_bit <= cap_val;
                low_all <= low_all & ~cap_val;
            end
            if (state == ST_STOP1 && cap) begin
                stop_bad <= ~cap_val;
                low_all  <= low_all & ~cap_val;
            end
            if (final_cap) begin
                out_valid <= 1'b1;
                out_data  <= shreg;
                out_perr  <= par_en & ((^shreg) ^ par_bit ^ par_odd);
                out_ferr  <= stop_bad | ~cap_val;
                out_brk   <= low_all & ~cap_val;
            end
        end
    end

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R8
    hunt_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> state == ST_HUNT);
    // R7
    brk_has_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_brk) |-> out_ferr);
    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data >> eff_len) == '0);
    // R2
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && centre_hit && rxd_s) |=> state == ST_HUNT);
    // R5
    perr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !par_en) |-> !out_perr);
endmodule

// File: rtl/async_rx_engine.sv
module async_rx_engine #(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_DATA    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_1x,
    input  logic                os_tick,
    input  logic                ext_clk,
    input  logic                rxd,
    input  logic [3:0]          cfg_len,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                two_stop,
    output logic                out_valid,
    output logic [MAX_DATA-1:0] out_data,
    output logic                out_perr,
    output logic                out_ferr,
    output logic                out_brk
);
    logic rxd_s, ext_rise, restart;
    logic centre_hit, vote_hit, end_hit, vote;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .ext_clk(ext_clk),
        .rxd_s(rxd_s), .ext_rise(ext_rise)
    );

    rx_os_sampler #(.OS_RATE(OS_RATE)) u_samp (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .restart(restart), .rxd_s(rxd_s),
        .centre_hit(centre_hit), .vote_hit(vote_hit), .end_hit(end_hit), .vote(vote)
    );

    rx_frame_fsm #(.MAX_DATA(MAX_DATA)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_1x(mode_1x), .os_tick(os_tick),
        .rxd_s(rxd_s), .ext_rise(ext_rise), .centre_hit(centre_hit),
        .vote_hit(vote_hit), .end_hit(end_hit), .vote(vote),
        .cfg_len(cfg_len), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .restart(restart), .out_valid(out_valid), .out_data(out_data),
        .out_perr(out_perr), .out_ferr(out_ferr), .out_brk(out_brk)
    );
endmodule

// File: tb/tb_async_rx_engine.sv
module tb_async_rx_engine;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, mode_1x, ext_clk, rxd, par_en, par_odd, two_stop;
    logic       os_tick = 1'b0;
    logic [3:0] cfg_len;
    logic       out_valid, out_perr, out_ferr, out_brk;
    logic [8:0] out_data;

    async_rx_engine dut (
        .clk(clk), .rst_n(rst_n), .mode_1x(mode_1x), .os_tick(os_tick),
        .ext_clk(ext_clk), .rxd(rxd), .cfg_len(cfg_len), .par_en(par_en),
        .par_odd(par_odd), .two_stop(two_stop), .out_valid(out_valid),
        .out_data(out_data), .out_perr(out_perr), .out_ferr(out_ferr), .out_brk(out_brk)
    );

    int n_chk = 0, n_bad = 0, rcnt = 0, run_err = 0, div = 0;
    logic       prev_v = 1'b0;
    logic [8:0] cap_d  [8];
    logic       cap_pe [8], cap_fe [8], cap_bk [8];

    always @(posedge clk) begin
        div     <= (div == 3) ? 0 : div + 1;
        os_tick <= (div == 3);
    end

    always @(negedge clk) begin
        if (out_valid) begin
            cap_d[rcnt % 8]  = out_data;
            cap_pe[rcnt % 8] = out_perr;
            cap_fe[rcnt % 8] = out_ferr;
            cap_bk[rcnt % 8] = out_brk;
            rcnt = rcnt + 1;
            if (prev_v) run_err = run_err + 1;
        end
        prev_v = out_valid;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] mask_of(input int len);
        return 9'((10'h1 << len) - 1);
    endfunction

    function automatic logic par_of(input logic [8:0] d, input int len, input logic po);
        return (^(d & mask_of(len))) ^ po;
    endfunction

    task automatic tick_wait(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!os_tick) @(posedge clk);
        end
    endtask

    task automatic hold(input logic lv, input int n);
        rxd <= lv;
        tick_wait(n);
    endtask

    task automatic build(input logic [8:0] d, input int len, input logic pe, input logic po,
                         input logic ts, input logic flip, input logic stopv,
                         output logic lv [14], output int nb);
        lv[0] = 1'b0;
        for (int k = 0; k < len; k++) lv[1 + k] = d[k];
        nb = 1 + len;
        if (pe) begin lv[nb] = par_of(d, len, po) ^ flip; nb++; end
        lv[nb] = stopv; nb++;
        if (ts) begin lv[nb] = stopv; nb++; end
    endtask

    task automatic send16(input logic [8:0] d, input int len, input logic pe, input logic po,
                          input logic ts, input logic flip, input logic stopv,
                          input int last_ticks, input int jit);
        logic lv [14];
        int nb, e_prev, e_next;
        build(d, len, pe, po, ts, flip, stopv, lv, nb);
        e_prev = 0;
        for (int b = 0; b < nb; b++) begin
            if (b == nb - 1) begin
                hold(lv[b], last_ticks - e_prev);
            end else begin
                e_next = (jit > 0) ? $urandom_range(0, 2 * jit) - jit : 0;
                hold(lv[b], 16 + e_next - e_prev);
                e_prev = e_next;
            end
        end
    endtask

    task automatic edge1x(input logic lv);
        rxd <= lv;
        repeat (6) @(posedge clk);
        ext_clk <= 1'b1;
        repeat (6) @(posedge clk);
        ext_clk <= 1'b0;
    endtask

    task automatic send1x(input logic [8:0] d, input int len, input logic pe, input logic po,
                          input logic ts, input logic flip);
        logic lv [14];
        int nb;
        build(d, len, pe, po, ts, flip, 1'b1, lv, nb);
        for (int b = 0; b < nb; b++) edge1x(lv[b]);
        for (int b = 0; b < 3; b++) edge1x(1'b1);
    endtask

    task automatic expect_word(input string req, input int base, input int slot_off,
                               input logic [8:0] d, input logic pe, input logic fe, input logic bk);
        int s;
        s = (base + slot_off) % 8;
        chk(req, "data", int'(cap_d[s]), int'(d));
        chk(req, "perr", int'(cap_pe[s]), int'(pe));
        chk(req, "ferr", int'(cap_fe[s]), int'(fe));
        chk(req, "brk", int'(cap_bk[s]), int'(bk));
    endtask

    task automatic cfg(input int len, input logic pe, input logic po, input logic ts);
        cfg_len = 4'(len); par_en = pe; par_odd = po; two_stop = ts;
    endtask

    bit done = 0;

    initial begin
        #(4 * 180000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base, len;
        logic pe, po, ts;
        logic [8:0] d;
        void'($urandom(32'd4321));
        rst_n = 1'b0; mode_1x = 1'b0; ext_clk = 1'b0; rxd = 1'b1;
        cfg(8, 1'b0, 1'b0, 1'b0);
        repeat (10) @(posedge clk);
        rst_n <= 1'b1;
        hold(1'b1, 20);
        @(negedge clk);
        chk("R1", "valid_idle", int'(out_valid), 0);
        chk("R1", "count_idle", rcnt, 0);

        // random oversampled frames: R4 plain, R3 with jittered edges, R5/R6 config mix
        for (int i = 0; i < 24; i++) begin
            len = $urandom_range(5, 9);
            pe = 1'($urandom); po = 1'($urandom); ts = 1'($urandom);
            d = 9'($urandom) & mask_of(len);
            cfg(len, pe, po, ts);
            base = rcnt;
            send16(d, len, pe, po, ts, 1'b0, 1'b1, 16, (i % 2) ? 3 : 0);
            hold(1'b1, 30);
            chk((i % 2) ? "R3" : "R4", "count", rcnt, base + 1);
            expect_word((i % 2) ? "R3" : "R4", base, 0, d, 1'b0, 1'b0, 1'b0);
        end

        // R4: out-of-range length clamps to 9
        cfg(12, 1'b0, 1'b0, 1'b0); base = rcnt;
        send16(9'h1A5, 9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16, 0);
        hold(1'b1, 30);
        chk("R4", "count_clamp", rcnt, base + 1);
        expect_word("R4", base, 0, 9'h1A5, 1'b0, 1'b0, 1'b0);

        // R3: single-sample glitch on sample 8 of data bit 0
        cfg(5, 1'b0, 1'b0, 1'b0); base = rcnt;
        hold(1'b0, 16); hold(1'b1, 8); hold(1'b0, 1); hold(1'b1, 7);
        hold(1'b0, 64); hold(1'b1, 16); hold(1'b1, 30);
        chk("R3", "count_glitch", rcnt, base + 1);
        expect_word("R3", base, 0, 9'h001, 1'b0, 1'b0, 1'b0);

        // R5: flipped parity bit, even and odd
        cfg(7, 1'b1, 1'b0, 1'b0); base = rcnt;
        send16(9'h05A, 7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16, 0);
        hold(1'b1, 30);
        expect_word("R5", base, 0, 9'h05A, 1'b1, 1'b0, 1'b0);
        cfg(8, 1'b1, 1'b1, 1'b1); base = rcnt;
        send16(9'h0C3, 8, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16, 0);
        hold(1'b1, 30);
        expect_word("R5", base, 0, 9'h0C3, 1'b1, 1'b0, 1'b0);

        // R6: low stop bit
        cfg(8, 1'b0, 1'b0, 1'b0); base = rcnt;
        send16(9'h0A5, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16, 0);
        hold(1'b1, 30);
        chk("R6", "count_ferr", rcnt, base + 1);
        expect_word("R6", base, 0, 9'h0A5, 1'b0, 1'b1, 1'b0);

        // R7: break, everything low including parity
        cfg(8, 1'b1, 1'b0, 1'b0); base = rcnt;
        send16(9'h000, 8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16, 0);
        hold(1'b1, 40);
        chk("R7", "count_brk", rcnt, base + 1);
        expect_word("R7", base, 0, 9'h000, 1'b0, 1'b1, 1'b1);

        // R2: false start of 5 samples
        cfg(8, 1'b0, 1'b0, 1'b0); base = rcnt;
        hold(1'b0, 5); hold(1'b1, 60);
        chk("R2", "count_false_start", rcnt, base);

        // R8: shortened stop then immediate start
        cfg(8, 1'b0, 1'b0, 1'b0); base = rcnt;
        send16(9'h03C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10, 0);
        send16(9'h0E1, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16, 0);
        hold(1'b1, 30);
        chk("R8", "count_short_stop", rcnt, base + 2);
        expect_word("R8", base, 0, 9'h03C, 1'b0, 1'b0, 1'b0);
        expect_word("R8", base, 1, 9'h0E1, 1'b0, 1'b0, 1'b0);

        // R10: 1x sampling mode
        mode_1x = 1'b1;
        for (int b = 0; b < 3; b++) edge1x(1'b1);
        for (int i = 0; i < 8; i++) begin
            len = $urandom_range(5, 9);
            pe = 1'($urandom); po = 1'($urandom); ts = 1'($urandom);
            d = 9'($urandom) & mask_of(len);
            cfg(len, pe, po, ts);
            base = rcnt;
            send1x(d, len, pe, po, ts, 1'b0);
            chk("R10", "count", rcnt, base + 1);
            expect_word("R10", base, 0, d, 1'b0, 1'b0, 1'b0);
        end
        cfg(6, 1'b1, 1'b0, 1'b0); base = rcnt;
        send1x(9'h02B, 6, 1'b1, 1'b0, 1'b0, 1'b1);
        expect_word("R10", base, 0, 9'h02B, 1'b1, 1'b0, 1'b0);

        // R9: every strobe lasted one cycle
        chk("R9", "multi_cycle_valid", run_err, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule